// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the stream of column addresses that a synchronous DRAM burst walks through. When a read or write is accepted, it captures the start column together with the programmed burst settings: a length code, an ordering bit and the single-beat-write option. From the next cycle on it presents one column address per beat, marks the final beat, and stops by itself at the end of a finite burst.

Two beat orderings are supported. The sequential ordering counts within an aligned window the size of the burst and wraps inside it. The interleaved ordering flips the low address bits by the beat number. A full-page setting walks the whole 512-column row and wraps at its end until something ends the burst. A burst-stop input or a new column command ends the current burst early, and a new command may arrive on any cycle. A low clock enable suspends the generator: its state holds and it produces no beat. A length code that is not defined gives a one-beat burst and raises an error flag.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is high and in the first cycle after it, `beat_vld`, `last_beat` and `mode_err` are all 0.
- R2: A `start` sampled with `cke` high makes the next cycle present the first beat: `beat_vld` is 1 and `beat_col` equals the sampled `start_col`.
- R3: Length codes on `bl_code` are 000 for 1 beat, 001 for 2, 010 for 4, 011 for 8 and 111 for full page. `last_beat` is 1 only on the final beat of a finite burst, and `beat_vld` is 0 in the cycle after that beat unless a new start was accepted.
- R4: With `btype` = 0 (sequential), beat k has the low log2(length) bits equal to (start + k) mod length. The remaining upper column bits equal those of the start column.
- R5: With `btype` = 1 (interleaved) and a length of 4 or 8, beat k equals the start column XOR k. For lengths 1 and 2 the order is the sequential one.
- R6: In full-page mode the column on beat k is (start + k) mod 512. The burst continues past 512 beats, and `last_beat` never rises.
- R7: When `single_wr` is 1 and `is_write` is 1 at the start, the burst is one beat long whatever `bl_code` holds. With `is_write` = 0, the programmed length applies.
- R8: A `stop` sampled with `cke` high and no `start` ends the burst: `beat_vld` is 0 from the next cycle.
- R9: A `start` accepted during a burst discards the rest of it and begins the new burst from its own column. Starts on back-to-back cycles each produce their own first beat.
- R10: While `cke` is low, `beat_vld` and `last_beat` are 0, `beat_col` holds, and `start` and `stop` are ignored. When `cke` returns high, the burst resumes at the beat it had reached.
- R11: A reserved length code (100, 101, 110) gives a one-beat burst and sets `mode_err` from the next cycle. `mode_err` then holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low suspends the generator |
| start | input | 1 | Column command strobe (read or write) |
| is_write | input | 1 | 1 when the command starting is a write |
| start_col | input | 9 | First column of the burst |
| stop | input | 1 | Burst terminate |
| bl_code | input | 3 | Burst length code |
| btype | input | 1 | Ordering: 0 sequential, 1 interleaved |
| single_wr | input | 1 | 1 forces writes to one beat |
| beat_col | output | 9 | Column address of the current beat |
| beat_vld | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | The presented beat is the final one |
| mode_err | output | 1 | The last accepted start used a reserved length code |

## Verification
The assertions check on every cycle the rules that hold at the ports alone. These are: the first beat after an accepted start, the end of activity after a stop or a final beat, the gating and freezing under a low clock enable, the one-beat forced write, and the reserved-code error. The column order inside a burst depends on the start column and the mode captured at the start, so only the bench's scenarios show it. These scenarios cover the wrapped sequential and XOR orders for every length, full-page wrap across column 511, restarts in the middle of a burst, and resumption after a suspend.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    localparam int COL_W   = 9;
    localparam int LG_W    = 4;
    localparam int FULL_LG = COL_W;

    typedef logic [COL_W-1:0] col_t;
    typedef logic [LG_W-1:0]  lg_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        lg_t    lg;      // log2 of the beat count
        logic   full;    // full-page, runs until terminated
        order_e order;
        logic   bad;     // reserved length code
    } burst_cfg_t;

    // ones in the low lg bits: the wrap window of a burst
    function automatic col_t lg_mask(lg_t lg);
        col_t m;
        m = '0;
        for (int b = 0; b < COL_W; b++) begin
            if (b < int'(lg)) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic burst_cfg_t decode_cfg(logic [2:0] code, logic ilv_sel,
                                              logic wr, logic one_wr);
        burst_cfg_t c;
        c.full  = 1'b0;
        c.bad   = 1'b0;
        c.order = ORD_SEQ;
        case (code)
            3'b000:  c.lg = lg_t'(0);
            3'b001:  c.lg = lg_t'(1);
            3'b010:  c.lg = lg_t'(2);
            3'b011:  c.lg = lg_t'(3);
            3'b111: begin
                c.lg   = lg_t'(FULL_LG);
                c.full = 1'b1;
            end
            default: begin
                c.lg  = lg_t'(0);
                c.bad = 1'b1;
            end
        endcase
        if (wr && one_wr) begin
            c.lg   = lg_t'(0);
            c.full = 1'b0;
        end
        if (ilv_sel && (c.lg == lg_t'(2) || c.lg == lg_t'(3))) c.order = ORD_ILV;
        return c;
    endfunction

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import colgen_pkg::*;
(
    input  logic [2:0]  bl_code,
    input  logic        btype,
    input  logic        is_write,
    input  logic        single_wr,
    output burst_cfg_t  cfg
);

    always_comb begin
        cfg = decode_cfg(bl_code, btype, is_write, single_wr);
    end

endmodule

// File: rtl/colgen_beat_ctl.sv
module colgen_beat_ctl
    import colgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cke,
    input  logic        start,
    input  logic        stop,
    input  col_t        start_col,
    input  burst_cfg_t  cfg_in,
    output logic        live,
    output col_t        base,
    output col_t        idx,
    output burst_cfg_t  cfg,
    output logic        last_idx,
    output logic        err
);

    always_comb begin
        last_idx = live && !cfg.full && (idx == lg_mask(cfg.lg));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 1'b0;
            base <= '0;
            idx  <= '0;
            cfg  <= '0;
            err  <= 1'b0;
        end else if (cke) begin
            if (start) begin
                live <= 1'b1;
                base <= start_col;
                idx  <= '0;
                cfg  <= cfg_in;
                err  <= cfg_in.bad;
            end else if (live) begin
                if (stop || last_idx) begin
                    live <= 1'b0;
                end else begin
                    idx <= idx + col_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
    import colgen_pkg::*;
(
    input  col_t    base,
    input  col_t    idx,
    input  lg_t     lg,
    input  order_e  order,
    output col_t    col
);

    col_t win;
    col_t sum;

    assign win = lg_mask(lg);
    assign sum = base + idx;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = win[b] ? ((order == ORD_ILV) ? (base[b] ^ idx[b]) : sum[b])
                               : base[b];
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cke,
    input  logic        start,
    input  logic        is_write,
    input  logic [8:0]  start_col,
    input  logic        stop,
    input  logic [2:0]  bl_code,
    input  logic        btype,
    input  logic        single_wr,
    output logic [8:0]  beat_col,
    output logic        beat_vld,
    output logic        last_beat,
    output logic        mode_err
);

    burst_cfg_t cfg_new;
    burst_cfg_t cfg_cur;
    logic       live;
    logic       last_idx;
    col_t       base;
    col_t       idx;

    colgen_mode_dec i_dec (
        .bl_code   (bl_code),
        .btype     (btype),
        .is_write  (is_write),
        .single_wr (single_wr),
        .cfg       (cfg_new)
    );

    colgen_beat_ctl i_ctl (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .cfg_in    (cfg_new),
        .live      (live),
        .base      (base),
        .idx       (idx),
        .cfg       (cfg_cur),
        .last_idx  (last_idx),
        .err       (mode_err)
    );

    colgen_addr_map i_map (
        .base  (base),
        .idx   (idx),
        .lg    (cfg_cur.lg),
        .order (cfg_cur.order),
        .col   (beat_col)
    );

    assign beat_vld  = live && cke;
    assign last_beat = last_idx && cke;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker (
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic       start,
    input logic       is_write,
    input logic [8:0] start_col,
    input logic       stop,
    input logic [2:0] bl_code,
    input logic       single_wr,
    input logic [8:0] beat_col,
    input logic       beat_vld,
    input logic       last_beat,
    input logic       mode_err
);

    logic reserved;
    assign reserved = (bl_code == 3'b100) || (bl_code == 3'b101) || (bl_code == 3'b110);

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
        (start && cke) |=> (beat_vld && beat_col == $past(start_col)));

    assert_last_is_beat_R3: assert property (@(posedge clk) disable iff (rst)
        last_beat |-> beat_vld);

    assert_end_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        (last_beat && cke && !start) |=> !beat_vld);

    assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
        (start && cke && is_write && single_wr) |=> last_beat);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (stop && cke && !start) |=> !beat_vld);

    assert_suspend_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (!beat_vld && !last_beat));

    assert_suspend_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cke |=> $stable(beat_col));

    assert_reserved_err_R11: assert property (@(posedge clk) disable iff (rst)
        (start && cke && reserved) |=> (mode_err && last_beat));

endmodule

bind sdram_burst_colgen colgen_checker i_colgen_checker (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .start     (start),
    .is_write  (is_write),
    .start_col (start_col),
    .stop      (stop),
    .bl_code   (bl_code),
    .single_wr (single_wr),
    .beat_col  (beat_col),
    .beat_vld  (beat_vld),
    .last_beat (last_beat),
    .mode_err  (mode_err)
);

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic       is_write = 1'b0;
    logic [8:0] start_col = '0;
    logic       stop = 1'b0;
    logic [2:0] bl_code = '0;
    logic       btype = 1'b0;
    logic       single_wr = 1'b0;
    logic [8:0] beat_col;
    logic       beat_vld;
    logic       last_beat;
    logic       mode_err;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen i_sdram_burst_colgen (
        .clk(clk), .rst(rst), .cke(cke), .start(start), .is_write(is_write),
        .start_col(start_col), .stop(stop), .bl_code(bl_code), .btype(btype),
        .single_wr(single_wr), .beat_col(beat_col), .beat_vld(beat_vld),
        .last_beat(last_beat), .mode_err(mode_err)
    );

    typedef struct packed {
        logic [2:0]      code;
        logic            bt;
        logic            wr;
        logic            sw;
        logic            err;
        logic [3:0]      n;
        logic [8:0]      col;
        logic [0:7][8:0] exp;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 9'd245, '{9'd245, 9'd246, 9'd247, 9'd244, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 9'd5,   '{9'd5, 9'd4, 9'd7, 9'd6, 9'd1, 9'd0, 9'd3, 9'd2}},
        '{3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 9'd13,  '{9'd13, 9'd14, 9'd15, 9'd8, 9'd9, 9'd10, 9'd11, 9'd12}},
        '{3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4, 9'd6,   '{9'd6, 9'd7, 9'd4, 9'd5, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 9'd3,   '{9'd3, 9'd2, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 9'd100, '{9'd100, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{3'b011, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 9'd9,   '{9'd9, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{3'b011, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8, 9'd9,   '{9'd9, 9'd10, 9'd11, 9'd12, 9'd13, 9'd14, 9'd15, 9'd8}},
        '{3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 9'd7,   '{9'd7, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4, 9'd511, '{9'd511, 9'd510, 9'd509, 9'd508, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 9'd255, '{9'd255, 9'd254, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at the falling edge, settle, then sample
    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=0", WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) step();
        settle();
        chk("R1 vld in reset", int'(beat_vld), 0);
        chk("R1 err in reset", int'(mode_err), 0);
        step(); rst = 1'b0; settle();
        chk("R1 vld after reset", int'(beat_vld), 0);
        chk("R1 last after reset", int'(last_beat), 0);
        chk("R1 err after reset", int'(mode_err), 0);

        // table of bursts: R3 R4 R5 R7 R11
        for (int e = 0; e < 11; e++) begin
            step();
            bl_code = VEC[e].code; btype = VEC[e].bt; is_write = VEC[e].wr;
            single_wr = VEC[e].sw; start_col = VEC[e].col; start = 1'b1;
            for (int k = 0; k < int'(VEC[e].n); k++) begin
                step(); start = 1'b0; settle();
                chk($sformatf("R2/R4/R5 vec%0d beat%0d col", e, k), int'(beat_col), int'(VEC[e].exp[k]));
                chk($sformatf("R3 vec%0d beat%0d vld", e, k), int'(beat_vld), 1);
                chk($sformatf("R3/R7 vec%0d beat%0d last", e, k), int'(last_beat),
                    (k == int'(VEC[e].n) - 1) ? 1 : 0);
                if (k == 0) chk($sformatf("R11 vec%0d err", e), int'(mode_err), int'(VEC[e].err));
            end
            step(); settle();
            chk($sformatf("R3 vec%0d ended", e), int'(beat_vld), 0);
        end
        is_write = 1'b0; single_wr = 1'b0; btype = 1'b0;

        // R10 suspend mid-burst
        step(); bl_code = 3'b011; start_col = 9'd0; start = 1'b1;
        step(); start = 1'b0; settle();
        chk("R10 beat0", int'(beat_col), 0);
        step(); settle();
        chk("R10 beat1", int'(beat_col), 1);
        for (int s = 0; s < 3; s++) begin
            step(); cke = 1'b0; stop = (s == 1); start = (s == 2); start_col = 9'd300; settle();
            chk("R10 vld gated", int'(beat_vld), 0);
            chk("R10 col held", int'(beat_col), 2);
        end
        step(); cke = 1'b1; stop = 1'b0; start = 1'b0; settle();
        chk("R10 resume col", int'(beat_col), 2);
        chk("R10 resume vld", int'(beat_vld), 1);

        // R8 stop mid-burst
        step(); stop = 1'b1; settle();
        chk("R8 beat at stop", int'(beat_col), 3);
        step(); stop = 1'b0; settle();
        chk("R8 ended", int'(beat_vld), 0);

        // R10 start ignored while suspended
        step(); cke = 1'b0; start = 1'b1; start_col = 9'd77;
        step(); cke = 1'b1; start = 1'b0; settle();
        chk("R10 start ignored", int'(beat_vld), 0);

        // R9 restarts on consecutive cycles and mid-burst
        step(); bl_code = 3'b011; start = 1'b1; start_col = 9'd40;
        step(); start_col = 9'd100; settle();
        chk("R9 first", int'(beat_col), 40);
        step(); start_col = 9'd200; settle();
        chk("R9 second", int'(beat_col), 100);
        step(); start = 1'b0; settle();
        chk("R9 third", int'(beat_col), 200);
        step(); settle();
        chk("R9 continue", int'(beat_col), 201);
        step(); bl_code = 3'b010; start = 1'b1; start_col = 9'd22;
        step(); start = 1'b0; settle();
        chk("R9 restart col", int'(beat_col), 22);
        step(); settle();
        chk("R9 restart next", int'(beat_col), 23);

        // R6 full page across the row end and past 512 beats
        step(); bl_code = 3'b111; start = 1'b1; start_col = 9'd510;
        for (int k = 0; k < 520; k++) begin
            step(); start = 1'b0; settle();
            chk("R6 col", int'(beat_col), (510 + k) % 512);
            chk("R6 no last", int'(last_beat), 0);
        end
        chk("R6 still vld", int'(beat_vld), 1);
        step(); stop = 1'b1;
        step(); stop = 1'b0; settle();
        chk("R8 full page stop", int'(beat_vld), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule